// File: doc/BRIEF.md
# Iterative Shrink Center Locator

This block locates two features of a small grayscale eye image: a bright spot (the light reflection on the cornea) and a dark area (the pupil). Pixels arrive one per cycle in raster order. Each pixel is compared against two thresholds as it arrives. The results are stored as two bit maps, one bit per pixel.

After a start pulse, every pixel of both maps is updated at once in each step. The updates follow a four-neighbour cellular rule. The block first applies one erosion step and then a parameterised number of growth steps. These clear isolated noise and close small holes. After that it erodes each map repeatedly until the map is empty.

The block finds where a region vanishes from the row and column OR projections of the map. The projections taken in the last step before the map empties give the row and column of the center. This replaces an arithmetic centroid. A one-cycle done pulse marks the point where both coordinate pairs and their valid flags are ready.

Top module: `eyeCenterLocator`

## Requirements
- R1: A loaded pixel sets its bright-map bit when its value is greater than or equal to `brightThr`, and its pupil-map bit when its value is less than or equal to `darkThr`. Pixels are written in row-major order with the column index running fastest. The write position restarts at row 0, column 0 after reset and after each accepted start.
- R2: Before the repeated erosion begins, each map receives exactly one erosion step and then EXPN growth steps. Erosion clears a set pixel if any of its four orthogonal neighbours is clear, and pixels outside the array count as clear. Growth sets a pixel if the pixel or any of its four orthogonal neighbours is set. As a result, a region smaller than 3x3 has vanished before the repeated erosion starts.
- R3: For a map that is not empty, the reported row is the lowest row index whose row OR is set in the map state just before the erosion that empties it. The reported column is the lowest column index whose column OR is set in that same state. The valid flag is then 1.
- R4: A map that is empty when the repeated erosion starts reports valid 0, row 0 and column 0.
- R5: Count the clock edge that samples start as edge 0. Done is high for exactly one cycle, after edge 2+EXPN+K, where K is the index (counted from 0) of the erosion step in which the later of the two maps finishes. K never exceeds max(ROWS,COLS)/2+EXPN-1.
- R6: The six result outputs change only in the cycle in which done is high. They hold their values between runs, while the next image is loaded and while the next run is in progress.
- R7: While a run is in progress, `pixValid` and `start` have no effect: they change neither the maps nor the next write position.
- R8: After reset, done, both valid flags and all four coordinates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | A pixel is presented on pixData this cycle |
| pixData | input | PIXW | Pixel gray value |
| brightThr | input | PIXW | Bright-spot threshold (inclusive lower bound) |
| darkThr | input | PIXW | Pupil threshold (inclusive upper bound) |
| start | input | 1 | Begin processing the loaded maps |
| done | output | 1 | One-cycle pulse when the results are updated |
| glintValid | output | 1 | Bright-spot center found |
| glintRow | output | clog2(ROWS) | Bright-spot center row |
| glintCol | output | clog2(COLS) | Bright-spot center column |
| pupilValid | output | 1 | Pupil center found |
| pupilRow | output | clog2(ROWS) | Pupil center row |
| pupilCol | output | clog2(COLS) | Pupil center column |

## Verification
The bench builds the block with 8 rows, 12 columns and one growth step. Because the array is not square, a swapped row and column index shows up in the results. With a single growth step, the number of repeated erosion steps stays short, so the exact done cycle can be predicted for every image. Pixels on the array edge also meet the outside-is-clear rule in both directions. The images include regions with tied minimum indices, values exactly at each threshold, isolated pixels, an image that is bright everywhere, and randomly placed rectangles.

// File: rtl/eyeCtrPkg.sv
`timescale 1ns/1ps
package eyeCtrPkg;
  typedef struct packed {
    logic wr;      // write one pixel bit into each map
    logic arm;     // clear per-map progress at start
    logic shrink;  // preliminary erosion
    logic grow;    // preliminary growth
    logic iter;    // repeated erosion step
    logic last;    // final allowed repeated step
  } stepStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_ITER} phase_t;
endpackage

// File: rtl/eyeCtrControl.sv
`timescale 1ns/1ps
module eyeCtrControl
  import eyeCtrPkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int EXPN = 2,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pixValid,
  input  logic        start,
  input  logic        allFin,
  output stepStrobe_t stb,
  output logic [RW-1:0] wrRow,
  output logic [CW-1:0] wrCol,
  output logic        done,
  output logic        busy
);
  localparam int CAP = (((ROWS > COLS) ? ROWS : COLS) / 2) + EXPN;
  localparam int PW  = (EXPN > 0) ? $clog2(EXPN + 1) : 1;
  localparam int IW  = (CAP > 1) ? $clog2(CAP) : 1;

  phase_t        phase;
  logic [PW-1:0] preCnt;
  logic [IW-1:0] iterCnt;

  always_comb begin
    stb        = '0;
    stb.wr     = (phase == PH_IDLE) && pixValid && !start;
    stb.arm    = (phase == PH_IDLE) && start;
    stb.shrink = (phase == PH_PRE) && (preCnt == '0);
    stb.grow   = (phase == PH_PRE) && (preCnt != '0);
    stb.iter   = (phase == PH_ITER);
    stb.last   = (phase == PH_ITER) && (iterCnt == IW'(CAP - 1));
  end

  assign busy = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      preCnt  <= '0;
      iterCnt <= '0;
      wrRow   <= '0;
      wrCol   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_PRE;
            preCnt <= '0;
            wrRow  <= '0;
            wrCol  <= '0;
          end else if (pixValid) begin
            if (wrCol == CW'(COLS - 1)) begin
              wrCol <= '0;
              wrRow <= (wrRow == RW'(ROWS - 1)) ? '0 : wrRow + 1'b1;
            end else begin
              wrCol <= wrCol + 1'b1;
            end
          end
        end
        PH_PRE: begin
          if (preCnt == PW'(EXPN)) begin
            phase   <= PH_ITER;
            iterCnt <= '0;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        PH_ITER: begin
          iterCnt <= iterCnt + 1'b1;
          if (allFin) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eyeCtrPlane.sv
`timescale 1ns/1ps
module eyeCtrPlane
  import eyeCtrPkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  stepStrobe_t   stb,
  input  logic [RW-1:0] wrRow,
  input  logic [CW-1:0] wrCol,
  input  logic          wrBit,
  output logic          finNext,
  output logic          nxtValid,
  output logic [RW-1:0] nxtRow,
  output logic [CW-1:0] nxtCol
);
  logic [ROWS-1:0][COLS-1:0] cellMap, shrunk, grown;
  logic [ROWS-1:0][COLS-1:0] upB, dnB, lfB, rtB;
  logic [ROWS-1:0] rowProj;
  logic [COLS-1:0] colProj;
  logic [RW-1:0]   lowRow, resRow;
  logic [CW-1:0]   lowCol, resCol;
  logic            isEmpty, willEmpty, fin, resValid, vanishNow;

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      if (r > 0) begin : gUp
        assign upB[r][c] = cellMap[r-1][c];
      end else begin : gUpEdge
        assign upB[r][c] = 1'b0;
      end
      if (r < ROWS - 1) begin : gDn
        assign dnB[r][c] = cellMap[r+1][c];
      end else begin : gDnEdge
        assign dnB[r][c] = 1'b0;
      end
      if (c > 0) begin : gLf
        assign lfB[r][c] = cellMap[r][c-1];
      end else begin : gLfEdge
        assign lfB[r][c] = 1'b0;
      end
      if (c < COLS - 1) begin : gRt
        assign rtB[r][c] = cellMap[r][c+1];
      end else begin : gRtEdge
        assign rtB[r][c] = 1'b0;
      end
      assign shrunk[r][c] = cellMap[r][c] & upB[r][c] & dnB[r][c] & lfB[r][c] & rtB[r][c];
      assign grown[r][c]  = cellMap[r][c] | upB[r][c] | dnB[r][c] | lfB[r][c] | rtB[r][c];
    end
    assign rowProj[r] = |cellMap[r];
  end

  always_comb begin
    colProj = '0;
    for (int r = 0; r < ROWS; r++) colProj = colProj | cellMap[r];
  end

  always_comb begin
    lowRow = '0;
    for (int i = ROWS - 1; i >= 0; i--) if (rowProj[i]) lowRow = RW'(i);
    lowCol = '0;
    for (int j = COLS - 1; j >= 0; j--) if (colProj[j]) lowCol = CW'(j);
  end

  assign isEmpty   = ~|rowProj;
  assign willEmpty = ~|shrunk;
  assign vanishNow = stb.iter && !fin && !isEmpty && willEmpty;
  assign finNext   = fin || (stb.iter && (isEmpty || willEmpty || stb.last));
  assign nxtValid  = fin ? resValid : vanishNow;
  assign nxtRow    = fin ? resRow : (vanishNow ? lowRow : '0);
  assign nxtCol    = fin ? resCol : (vanishNow ? lowCol : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cellMap  <= '0;
      fin      <= 1'b0;
      resValid <= 1'b0;
      resRow   <= '0;
      resCol   <= '0;
    end else begin
      if (stb.wr)     cellMap[wrRow][wrCol] <= wrBit;
      if (stb.shrink) cellMap <= shrunk;
      if (stb.grow)   cellMap <= grown;
      if (stb.arm) begin
        fin      <= 1'b0;
        resValid <= 1'b0;
        resRow   <= '0;
        resCol   <= '0;
      end
      if (stb.iter && !fin) begin
        if (isEmpty) begin
          fin <= 1'b1;
        end else begin
          cellMap  <= shrunk;
          fin      <= willEmpty || stb.last;
          resValid <= willEmpty;
          if (willEmpty) begin
            resRow <= lowRow;
            resCol <= lowCol;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eyeCtrData.sv
`timescale 1ns/1ps
module eyeCtrData
  import eyeCtrPkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int PIXW = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  stepStrobe_t     stb,
  input  logic [RW-1:0]   wrRow,
  input  logic [CW-1:0]   wrCol,
  input  logic [PIXW-1:0] pixData,
  input  logic [PIXW-1:0] brightThr,
  input  logic [PIXW-1:0] darkThr,
  output logic            allFin,
  output logic            glintValid,
  output logic [RW-1:0]   glintRow,
  output logic [CW-1:0]   glintCol,
  output logic            pupilValid,
  output logic [RW-1:0]   pupilRow,
  output logic [CW-1:0]   pupilCol
);
  logic [1:0]    wrBit, finNext, nxtValid;
  logic [RW-1:0] nxtRow [2];
  logic [CW-1:0] nxtCol [2];

  assign wrBit[0] = (pixData >= brightThr);
  assign wrBit[1] = (pixData <= darkThr);

  for (genvar g = 0; g < 2; g++) begin : gPlane
    eyeCtrPlane #(.ROWS(ROWS), .COLS(COLS)) uPlane (
      .clk(clk), .rst(rst), .stb(stb), .wrRow(wrRow), .wrCol(wrCol),
      .wrBit(wrBit[g]), .finNext(finNext[g]), .nxtValid(nxtValid[g]),
      .nxtRow(nxtRow[g]), .nxtCol(nxtCol[g])
    );
  end

  assign allFin = &finNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      glintValid <= 1'b0;
      glintRow   <= '0;
      glintCol   <= '0;
      pupilValid <= 1'b0;
      pupilRow   <= '0;
      pupilCol   <= '0;
    end else if (stb.iter && allFin) begin
      glintValid <= nxtValid[0];
      glintRow   <= nxtRow[0];
      glintCol   <= nxtCol[0];
      pupilValid <= nxtValid[1];
      pupilRow   <= nxtRow[1];
      pupilCol   <= nxtCol[1];
    end
  end
endmodule

// File: rtl/eyeCenterLocator.sv
`timescale 1ns/1ps
module eyeCenterLocator
  import eyeCtrPkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int PIXW = 8,
  parameter int EXPN = 2,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pixValid,
  input  logic [PIXW-1:0] pixData,
  input  logic [PIXW-1:0] brightThr,
  input  logic [PIXW-1:0] darkThr,
  input  logic            start,
  output logic            done,
  output logic            glintValid,
  output logic [RW-1:0]   glintRow,
  output logic [CW-1:0]   glintCol,
  output logic            pupilValid,
  output logic [RW-1:0]   pupilRow,
  output logic [CW-1:0]   pupilCol
);
  stepStrobe_t   stb;
  logic [RW-1:0] wrRow;
  logic [CW-1:0] wrCol;
  logic          allFin;
  logic          busy;

  eyeCtrControl #(.ROWS(ROWS), .COLS(COLS), .EXPN(EXPN)) uCtrl (
    .clk(clk), .rst(rst), .pixValid(pixValid), .start(start), .allFin(allFin),
    .stb(stb), .wrRow(wrRow), .wrCol(wrCol), .done(done), .busy(busy)
  );

  eyeCtrData #(.ROWS(ROWS), .COLS(COLS), .PIXW(PIXW)) uData (
    .clk(clk), .rst(rst), .stb(stb), .wrRow(wrRow), .wrCol(wrCol),
    .pixData(pixData), .brightThr(brightThr), .darkThr(darkThr), .allFin(allFin),
    .glintValid(glintValid), .glintRow(glintRow), .glintCol(glintCol),
    .pupilValid(pupilValid), .pupilRow(pupilRow), .pupilCol(pupilCol)
  );
endmodule

// File: rtl/eyeCenterLocatorChk.sv
`timescale 1ns/1ps
module eyeCenterLocatorChk #(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int EXPN = 2,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          glintValid,
  input logic [RW-1:0] glintRow,
  input logic [CW-1:0] glintCol,
  input logic          pupilValid,
  input logic [RW-1:0] pupilRow,
  input logic [CW-1:0] pupilCol
);
  localparam int CAP = (((ROWS > COLS) ? ROWS : COLS) / 2) + EXPN;
  localparam int LIM = 1 + EXPN + CAP;

  logic [15:0] busyCnt;
  always_ff @(posedge clk) begin
    if (rst || !busy) busyCnt <= '0;
    else              busyCnt <= busyCnt + 1'b1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (rst) busy |-> (busyCnt < 16'(LIM)));
  // R4
  glint_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !glintValid |-> (glintRow == '0 && glintCol == '0));
  // R4
  pupil_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pupilValid |-> (pupilRow == '0 && pupilCol == '0));
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({glintValid, glintRow, glintCol, pupilValid, pupilRow, pupilCol}));
endmodule

bind eyeCenterLocator eyeCenterLocatorChk #(.ROWS(ROWS), .COLS(COLS), .EXPN(EXPN)) uChk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .glintValid(glintValid), .glintRow(glintRow), .glintCol(glintCol),
  .pupilValid(pupilValid), .pupilRow(pupilRow), .pupilCol(pupilCol)
);

// File: tb/sim_eyeCenterLocator.sv
`timescale 1ns/1ps
module sim_eyeCenterLocator;
  localparam int NR = 8, NC = 12, PW = 8, NE = 1;
  localparam int CAP = (((NR > NC) ? NR : NC) / 2) + NE;

  logic clk = 1'b0, rst = 1'b1;
  logic pixValid = 1'b0, start = 1'b0;
  logic [PW-1:0] pixData = '0, brightThr = 8'd200, darkThr = 8'd40;
  logic done, glintValid, pupilValid;
  logic [2:0] glintRow, pupilRow;
  logic [3:0] glintCol, pupilCol;

  eyeCenterLocator #(.ROWS(NR), .COLS(NC), .PIXW(PW), .EXPN(NE)) u0 (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixData(pixData),
    .brightThr(brightThr), .darkThr(darkThr), .start(start), .done(done),
    .glintValid(glintValid), .glintRow(glintRow), .glintCol(glintCol),
    .pupilValid(pupilValid), .pupilRow(pupilRow), .pupilCol(pupilCol)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int img [NR][NC];
  bit cur [NR][NC];
  bit tmp [NR][NC];
  int prev [6];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cellAt(input int r, input int c);
    if (r < 0 || r >= NR || c < 0 || c >= NC) return 1'b0;
    return cur[r][c];
  endfunction

  task automatic stepOp(input bit grow);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        int n = int'(cellAt(r-1,c)) + int'(cellAt(r+1,c)) + int'(cellAt(r,c-1)) + int'(cellAt(r,c+1));
        if (grow) tmp[r][c] = cur[r][c] || (n > 0);
        else      tmp[r][c] = cur[r][c] && (n == 4);
      end
    cur = tmp;
  endtask

  function automatic bit mapEmpty();
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) if (cur[r][c]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic analyze(output int k, output int v, output int rr, output int cc);
    stepOp(1'b0);
    for (int e = 0; e < NE; e++) stepOp(1'b1);
    k = 0; v = 0; rr = 0; cc = 0;
    if (mapEmpty()) return;
    for (int it = 0; it < CAP; it++) begin
      int lr = NR, lc = NC;
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++)
          if (cur[r][c]) begin
            if (r < lr) lr = r;
            if (c < lc) lc = c;
          end
      stepOp(1'b0);
      k = it;
      if (mapEmpty()) begin v = 1; rr = lr; cc = lc; return; end
    end
  endtask

  task automatic fill(input int val);
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) img[r][c] = val;
  endtask

  task automatic rect(input int r0, input int c0, input int h, input int w, input int val);
    for (int r = r0; r < r0 + h; r++)
      for (int c = c0; c < c0 + w; c++)
        if (r < NR && c < NC) img[r][c] = val;
  endtask

  task automatic runImage(input string req, input bit noise);
    int kg, vg, rg, cg, kp, vp, rp, cp, kMax, lat;
    int got [6];
    int exp [6];
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) cur[r][c] = (img[r][c] >= int'(brightThr));
    analyze(kg, vg, rg, cg);
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) cur[r][c] = (img[r][c] <= int'(darkThr));
    analyze(kp, vp, rp, cp);
    kMax = (kg > kp) ? kg : kp;
    lat = 2 + NE + kMax;
    exp = '{vg, rg, cg, vp, rp, cp};
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) begin
        @(negedge clk);
        pixValid = 1'b1; pixData = PW'(img[r][c]);
      end
    @(negedge clk); pixValid = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int n = 0; n <= lat + 2; n++) begin
      got = '{int'(glintValid), int'(glintRow), int'(glintCol),
              int'(pupilValid), int'(pupilRow), int'(pupilCol)};
      check(done == (n == lat), {req, " R5 done timing"}, int'(done), int'(n == lat));
      if (n == lat) begin
        check(got[0] == exp[0], {req, " R3/R4 glint valid"}, got[0], exp[0]);
        check(got[1] == exp[1] && got[2] == exp[2], {req, " R3 glint row*16+col"},
              got[1]*16 + got[2], exp[1]*16 + exp[2]);
        check(got[3] == exp[3], {req, " R3/R4 pupil valid"}, got[3], exp[3]);
        check(got[4] == exp[4] && got[5] == exp[5], {req, " R3 pupil row*16+col"},
              got[4]*16 + got[5], exp[4]*16 + exp[5]);
        prev = exp;
      end else begin
        // R6: results hold outside the done cycle
        check(got == prev, {req, " R6 hold"}, got[0]*1000 + got[1]*16 + got[2], prev[0]*1000 + prev[1]*16 + prev[2]);
      end
      if (noise && n < lat) begin
        pixValid = 1'b1; pixData = PW'($urandom_range(0, 255)); start = 1'b1;
      end else begin
        pixValid = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
    pixValid = 1'b0; start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    prev = '{0, 0, 0, 0, 0, 0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(done == 1'b0, "R8 done", int'(done), 0);
    check(glintValid == 1'b0 && pupilValid == 1'b0, "R8 valids", int'(glintValid) + int'(pupilValid), 0);
    check(glintRow == 0 && glintCol == 0 && pupilRow == 0 && pupilCol == 0, "R8 coords",
          int'(glintRow) + int'(glintCol) + int'(pupilRow) + int'(pupilCol), 0);

    // R3: square glint, 4x4 pupil with tied minimum indices
    fill(128); rect(1, 8, 3, 3, 230); rect(3, 1, 4, 4, 10);
    runImage("R3 squares", 1'b0);

    // R4: no bright pixels at all
    fill(128); rect(2, 5, 3, 4, 5);
    runImage("R4 no glint", 1'b0);

    // R2: isolated pixels and a 2x2 block vanish in the first erosion
    fill(128); img[0][0] = 255; rect(4, 4, 2, 2, 255); img[7][11] = 0;
    runImage("R2 isolated", 1'b0);

    // R1: values exactly at each threshold count
    fill(128); rect(0, 0, 3, 5, 200); rect(4, 6, 4, 6, 40); rect(5, 0, 3, 3, 199);
    runImage("R1 thresholds", 1'b0);

    // R2: whole image bright, border meets outside-clear rule
    fill(255);
    runImage("R2 full", 1'b0);

    // R7: inputs pulsed during processing are ignored
    fill(128); rect(1, 8, 3, 3, 230); rect(3, 1, 4, 4, 10);
    runImage("R7 noise", 1'b1);
    fill(128); rect(2, 2, 5, 4, 250); rect(0, 7, 3, 5, 20);
    runImage("R7 after noise", 1'b0);

    for (int t = 0; t < 6; t++) begin
      fill(128);
      rect($urandom_range(0, NR-1), $urandom_range(0, NC-1), $urandom_range(1, 6), $urandom_range(1, 8), 240);
      rect($urandom_range(0, NR-1), $urandom_range(0, NC-1), $urandom_range(1, 6), $urandom_range(1, 8), 15);
      runImage("R3 random", 1'b0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule